// File: doc/BRIEF.md
# Transmit Abort and Restart Controller

This block supervises the transmit side of a synchronous serial link. It grants buffers to the serializer, and it watches the clear-to-send (CTS) handshake line while a buffer is on the wire. If the peer withdraws CTS for a full bit time during a buffer, and the link is not set up to leave CTS handling to software, the buffer is aborted. The controller then closes the buffer with a CTS-lost status, pulses a transmit-error interrupt when that interrupt is enabled, and locks the transmitter. Only an explicit restart command unlocks it.

Buffer starts use a valid/ready handshake. A start is taken on a cycle where `buf_valid_i` and `buf_ready_o` are both high. `buf_ready_o` is high only while the controller is idle, so an upstream source must hold `buf_valid_i` and wait through a send or a lock-out. Completion, close, status and interrupt signals are plain level or pulse pins and have no back-pressure. CTS is asynchronous to the block and passes through a two-flop synchronizer before it is qualified.

Top module: `txab_ctrl`

## Requirements
- R1: While a buffer is being sent with software CTS mode off, a CTS low level that lasts `BIT_CLKS` synchronized cycles aborts the buffer. If `cts_i` falls just after clock edge 0, `tx_en_o` is still high after edge `BIT_CLKS+2` and is low after edge `BIT_CLKS+3`.
- R2: Every buffer close is a single-cycle `close_o` pulse. During that pulse `close_stat_o` is one-hot: bit 0 set means the buffer was aborted by CTS loss, and bit 1 set means it completed normally.
- R3: `tx_err_irq_o` pulses in the same cycle as an abort close if `irq_en_i` is high, and it stays low if `irq_en_i` is low. It never pulses on a normal close.
- R4: After an abort the transmitter stays locked, with `tx_en_o` and `buf_ready_o` both low, whatever `cts_i` and `buf_valid_i` do. A `restart_i` strobe makes `buf_ready_o` high after the next edge.
- R5: With `sw_cts_i` high, CTS transitions never abort a buffer, however long CTS stays low.
- R6: A CTS drop while no buffer is being sent causes no close, and CTS low time is counted only during a send.
- R7: `restart_i` has no effect unless the transmitter is locked.
- R8: A synchronized CTS low run of `BIT_CLKS-1` cycles does not abort. A run of exactly `BIT_CLKS` cycles does.
- R9: Asserting `buf_done_i` during a send closes the buffer with the normal-completion status and returns to idle. If the CTS-loss condition is present in the same cycle, the abort wins.
- R10: After reset, `buf_ready_o` is high and `tx_en_o`, `close_o` and `tx_err_irq_o` are low. A handshake makes `tx_en_o` high after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cts_i | input | 1 | Clear-to-send from the peer, high = granted, asynchronous |
| sw_cts_i | input | 1 | High: software handles CTS, no hardware abort |
| restart_i | input | 1 | Restart-transmit command strobe |
| irq_en_i | input | 1 | Transmit-error interrupt enable |
| buf_valid_i | input | 1 | A buffer is ready to be sent |
| buf_ready_o | output | 1 | Controller will accept a buffer |
| buf_done_i | input | 1 | Serializer has sent the last bit of the buffer |
| tx_en_o | output | 1 | Transmit enable to the serializer |
| close_o | output | 1 | Buffer-close strobe |
| close_stat_o | output | 2 | Close status: bit 0 CTS lost, bit 1 normal completion |
| tx_err_irq_o | output | 1 | Transmit-error interrupt pulse |

## Verification
Each kind of wrong internal state shows at the ports. A loss counter that is off by one moves the `tx_en_o` fall by one cycle, and a glitch of `BIT_CLKS-1` cycles or a drop of exactly `BIT_CLKS` cycles then gives the wrong answer within a few cycles of the CTS edge. A lock-out state that leaks shows as `buf_ready_o` or `tx_en_o` rising before a restart, or as a restart that fails to reopen the handshake on the next cycle. Status or interrupt bits that are crossed or stuck show in the close pulse itself, which is compared against the expected close for the scenario that caused it.

// File: rtl/txab_pkg.sv
`timescale 1ns/1ps
package txab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HALT = 2'd2
  } tx_state_e;

  localparam int STAT_W      = 2;
  localparam int STAT_CTS    = 0;
  localparam int STAT_NORMAL = 1;
endpackage

// File: rtl/txab_cts_sync.sv
`timescale 1ns/1ps
module txab_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/txab_loss_timer.sv
`timescale 1ns/1ps
module txab_loss_timer #(
  parameter int BIT_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic cts_s_i,
  output logic lost_o
);
  localparam int CW = $clog2(BIT_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BIT_CLKS);

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_cnt_q <= '0;
    else if (!arm_i || cts_s_i) low_cnt_q <= '0;
    else if (low_cnt_q != LIMIT) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign lost_o = arm_i && (low_cnt_q == LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt_q <= LIMIT); // R8
  AST_LOST_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && $past(arm_i)) |-> !$past(cts_s_i)); // R8
endmodule

// File: rtl/txab_fsm.sv
`timescale 1ns/1ps
module txab_fsm
  import txab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_cts_i,
  input  logic              restart_i,
  input  logic              irq_en_i,
  input  logic              buf_valid_i,
  input  logic              buf_done_i,
  input  logic              lost_i,
  output logic              arm_o,
  output logic              buf_ready_o,
  output logic              tx_en_o,
  output logic              close_o,
  output logic [STAT_W-1:0] close_stat_o,
  output logic              tx_err_irq_o
);
  tx_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      close_o      <= 1'b0;
      close_stat_o <= '0;
      tx_err_irq_o <= 1'b0;
    end else begin
      close_o      <= 1'b0;
      close_stat_o <= '0;
      tx_err_irq_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (buf_valid_i) state_q <= ST_SEND;
        ST_SEND: begin
          if (lost_i && !sw_cts_i) begin
            state_q                <= ST_HALT;
            close_o                <= 1'b1;
            close_stat_o[STAT_CTS] <= 1'b1;
            tx_err_irq_o           <= irq_en_i;
          end else if (buf_done_i) begin
            state_q                   <= ST_IDLE;
            close_o                   <= 1'b1;
            close_stat_o[STAT_NORMAL] <= 1'b1;
          end
        end
        ST_HALT: if (restart_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arm_o       = (state_q == ST_SEND) && !sw_cts_i;
  assign buf_ready_o = (state_q == ST_IDLE);
  assign tx_en_o     = (state_q == ST_SEND);

  AST_STAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    close_o |-> $onehot(close_stat_o)); // R2
  AST_IRQ_ONLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_irq_o |-> (close_o && close_stat_o[STAT_CTS])); // R3
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !restart_i) |=> (state_q == ST_HALT)); // R4
  AST_SW_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && sw_cts_i) |=> !(close_o && close_stat_o[STAT_CTS])); // R5
  AST_IDLE_NO_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !close_o); // R6
  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !buf_valid_i) |=> (state_q == ST_IDLE)); // R7
endmodule

// File: rtl/txab_ctrl.sv
`timescale 1ns/1ps
module txab_ctrl
  import txab_pkg::*;
#(
  parameter int BIT_CLKS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_i,
  input  logic              sw_cts_i,
  input  logic              restart_i,
  input  logic              irq_en_i,
  input  logic              buf_valid_i,
  output logic              buf_ready_o,
  input  logic              buf_done_i,
  output logic              tx_en_o,
  output logic              close_o,
  output logic [STAT_W-1:0] close_stat_o,
  output logic              tx_err_irq_o
);
  logic cts_s;
  logic arm;
  logic lost;

  txab_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cts_i), .sync_o(cts_s)
  );

  txab_loss_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .cts_s_i(cts_s), .lost_o(lost)
  );

  txab_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_cts_i(sw_cts_i), .restart_i(restart_i),
    .irq_en_i(irq_en_i), .buf_valid_i(buf_valid_i), .buf_done_i(buf_done_i),
    .lost_i(lost), .arm_o(arm), .buf_ready_o(buf_ready_o), .tx_en_o(tx_en_o),
    .close_o(close_o), .close_stat_o(close_stat_o), .tx_err_irq_o(tx_err_irq_o)
  );

  AST_NO_SEND_AND_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en_o && buf_ready_o)); // R10
  AST_CLOSE_ENDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    close_o |-> !tx_en_o); // R1
endmodule

// File: tb/test_txab_ctrl.sv
`timescale 1ns/1ps
module test_txab_ctrl;
  localparam int B = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_i = 1'b1, sw_cts_i = 1'b0, restart_i = 1'b0, irq_en_i = 1'b1;
  logic buf_valid_i = 1'b0, buf_done_i = 1'b0;
  logic buf_ready_o, tx_en_o, close_o, tx_err_irq_o;
  logic [1:0] close_stat_o;

  int vectors = 0;
  int fails = 0;
  int closes = 0;
  logic [2:0] exp_q[$];

  always #2.5 clk = ~clk;

  txab_ctrl #(.BIT_CLKS(B)) i_txab_ctrl (
    .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .sw_cts_i(sw_cts_i),
    .restart_i(restart_i), .irq_en_i(irq_en_i), .buf_valid_i(buf_valid_i),
    .buf_ready_o(buf_ready_o), .buf_done_i(buf_done_i), .tx_en_o(tx_en_o),
    .close_o(close_o), .close_stat_o(close_stat_o), .tx_err_irq_o(tx_err_irq_o)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Expected close: {irq, stat[1:0]}
  task automatic expect_close(input logic [1:0] st, input logic irq);
    exp_q.push_back({irq, st});
  endtask

  task automatic start_buf();
    buf_valid_i = 1'b1;
    step(1);
    buf_valid_i = 1'b0;
    chk(tx_en_o, 1'b1, "R10 tx_en after handshake");
    chk(buf_ready_o, 1'b0, "R10 ready low while sending");
  endtask

  task automatic do_restart();
    restart_i = 1'b1;
    step(1);
    restart_i = 1'b0;
    chk(buf_ready_o, 1'b1, "R4 ready after restart");
  endtask

  // Monitor: pops an expected close whenever the design closes a buffer
  always @(negedge clk) begin
    if (rst_n) begin
      if (close_o) begin
        closes++;
        vectors++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected close: got stat=%b irq=%b expected none",
                   close_stat_o, tx_err_irq_o);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          if ({tx_err_irq_o, close_stat_o} !== e) begin
            fails++;
            $display("FAIL R2/R3 close: got irq=%b stat=%b expected irq=%b stat=%b",
                     tx_err_irq_o, close_stat_o, e[2], e[1:0]);
          end
        end
      end else if (tx_err_irq_o) begin
        fails++;
        vectors++;
        $display("FAIL R3 irq without close: got 1 expected 0");
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk(buf_ready_o, 1'b1, "R10 ready after reset");
    chk(tx_en_o, 1'b0, "R10 tx_en after reset");
    chk(close_o, 1'b0, "R10 close after reset");

    // R9 normal completion
    start_buf();
    expect_close(2'b10, 1'b0);
    buf_done_i = 1'b1; step(1); buf_done_i = 1'b0;
    chk(tx_en_o, 1'b0, "R9 tx_en after done");
    chk(buf_ready_o, 1'b1, "R9 idle after done");

    // R7 restart while idle has no effect, R8 short glitch
    restart_i = 1'b1; step(1); restart_i = 1'b0;
    chk(buf_ready_o, 1'b1, "R7 restart in idle");
    start_buf();
    cts_i = 1'b0; step(B - 1); cts_i = 1'b1; step(10);
    chk(tx_en_o, 1'b1, "R8 glitch of BIT_CLKS-1 ignored");
    restart_i = 1'b1; step(1); restart_i = 1'b0;
    chk(tx_en_o, 1'b1, "R7 restart during send ignored");

    // R1 abort timing, R3 irq enabled
    expect_close(2'b01, 1'b1);
    cts_i = 1'b0;
    step(B + 2);
    chk(tx_en_o, 1'b1, "R1 tx_en before qualification");
    step(1);
    chk(tx_en_o, 1'b0, "R1 tx_en dropped on loss");
    chk(tx_err_irq_o, 1'b1, "R3 irq with abort");
    step(1);
    cts_i = 1'b1; step(5);
    chk(tx_en_o, 1'b0, "R4 locked tx_en");
    chk(buf_ready_o, 1'b0, "R4 locked ready");
    buf_valid_i = 1'b1; step(3); buf_valid_i = 1'b0;
    chk(tx_en_o, 1'b0, "R4 valid ignored while locked");
    do_restart();

    // R6 drop while idle
    cts_i = 1'b0; step(20);
    chk(tx_en_o, 1'b0, "R6 idle drop tx_en");
    chk(buf_ready_o, 1'b1, "R6 idle drop no lock");
    cts_i = 1'b1; step(3);

    // R8 exact boundary, R3 irq disabled
    irq_en_i = 1'b0;
    start_buf();
    expect_close(2'b01, 1'b0);
    cts_i = 1'b0; step(B); cts_i = 1'b1; step(10);
    chk(tx_en_o, 1'b0, "R8 low of BIT_CLKS aborts");
    chk(buf_ready_o, 1'b0, "R8 locked after boundary abort");
    do_restart();
    irq_en_i = 1'b1;

    // R5 software CTS mode
    sw_cts_i = 1'b1;
    start_buf();
    cts_i = 1'b0; step(30);
    chk(tx_en_o, 1'b1, "R5 no abort in software mode");
    expect_close(2'b10, 1'b0);
    buf_done_i = 1'b1; step(1); buf_done_i = 1'b0;
    chk(buf_ready_o, 1'b1, "R5 normal close in software mode");
    cts_i = 1'b1; sw_cts_i = 1'b0; step(3);

    // R9 loss and done in the same cycle: abort wins
    start_buf();
    expect_close(2'b01, 1'b1);
    cts_i = 1'b0;
    step(B + 2);
    buf_done_i = 1'b1; step(1); buf_done_i = 1'b0;
    chk(tx_en_o, 1'b0, "R9 priority tx_en");
    chk(buf_ready_o, 1'b0, "R9 abort wins over done");
    cts_i = 1'b1; step(2);
    do_restart();

    step(3);
    vectors++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing closes: got %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule